// File: doc/BRIEF.md
# Expandable Multi-Die Instruction Register Chain

This block is the instruction-loading path of a stacked-die test wrapper. Each die owns a five-bit die-level instruction register. Behind it sit two three-bit instruction segments that belong to that die's embedded cores. Every register has a shift stage and an update stage. The serial path runs from `wsi` through the dies in order and ends at `wso`.

After reset the path holds only the die-level registers. When a die's active (update-stage) instruction selects internal test, that die's two core segments are spliced into the path right behind its die register. Software can then load core instructions through the longer chain. Dies in bypass or boundary test keep their core segments out of the path, so the chain is never longer than needed.

The current chain length is reported on a status output. The active die and core instructions are driven out to the test logic they control.

Top module: `wir_hier_chain`

## Requirements
- R1: While `rst_n` is low, every active die instruction is 0 (bypass), every active core instruction is 0, and `chain_len` equals NUM_DIES*DIE_W (15 by default).
- R2: While shifting, the active die and core instructions keep their previous values. A new instruction becomes active only through an update.
- R3: On a clock edge with `sel_wir` and `update_wr` both high, each in-path register copies its shift stage into its active stage. The new value is visible after that edge.
- R4: Shifting happens on an edge with `sel_wir` and `shift_wr` both high. Each register moves toward bit 0, and bit 0 leaves first. The path runs from `wsi` to die 0, then to die 1 and onward, ending at `wso`. After reset a bit on `wsi` appears on `wso` after exactly NUM_DIES*DIE_W shift edges.
- R5: The test-select field is bits [2:1] of a die instruction. Value 01 selects internal test. That value splices the die's two core segments into the path, which adds 2*CORE_W bits (6 by default) to `chain_len`.
- R6: Test-select values 00 (bypass), 10 (boundary test) and 11 (reserved) keep the core segments out of the path. The die's active core instructions do not change. Bits 4, 3 and 0 (parallel, post-bond, elevator) have no effect on splicing.
- R7: Inside a spliced die the order is die register, then core 0, then core 1, then the next die. Loading through the longer chain sets the core instructions.
- R8: Splicing follows the active stage, not the shift stage. `chain_len` and the path change only at an update edge and never during a shift.
- R9: With `sel_wir` low, `shift_wr` and `update_wr` are ignored. No shift stage moves and no active instruction changes.
- R10: Asserting `rst_n` low at any time, even in the middle of a shift, immediately returns all instructions to 0. It also collapses the chain to its die-only length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Wrapper test clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wsi | input | 1 | Serial instruction input |
| sel_wir | input | 1 | Selects the instruction registers |
| shift_wr | input | 1 | Shift enable |
| update_wr | input | 1 | Update enable |
| wso | output | 1 | Serial instruction output |
| die_instr | output | NUM_DIES*DIE_W | Active die instructions, die d at [d*DIE_W +: DIE_W] |
| core_instr | output | NUM_DIES*CORES_PER_DIE*CORE_W | Active core instructions, core c of die d at slot d*CORES_PER_DIE+c |
| chain_len | output | clog2(max length+1) | Current serial path length in bits |

## Verification
On every cycle the assertions check three things:
- active instructions and the chain length move only at a selected update edge;
- a die whose active code is not internal test leaves its core instructions frozen;
- reset forces the bypass state.

The bench scenarios are needed for the rest:
- the actual serial delay through a collapsed and an expanded chain;
- the bit ordering of die and core segments;
- the decoding of each test-select value;
- the fact that core segments of a die spliced only by the current update are not loaded by it;
- recovery from a reset asserted mid-shift.

// File: rtl/wir_chain_pkg.sv
package wir_chain_pkg;

  // Test-select field inside a die-level instruction.
  typedef enum logic [1:0] {
    TSEL_BYPASS = 2'b00,
    TSEL_INTEST = 2'b01,
    TSEL_EXTEST = 2'b10,
    TSEL_RSVD   = 2'b11
  } tsel_e;

  localparam int TSEL_LSB = 1;
  localparam int TSEL_W   = 2;

  function automatic logic splices(input logic [TSEL_W-1:0] field);
    return field == TSEL_INTEST;
  endfunction

endpackage

// File: rtl/wir_seg.sv
// One instruction register: serial shift stage plus parallel update stage.
module wir_seg #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         upd_en,
  input  logic         si,
  output logic         so,
  output logic [W-1:0] active
);

  logic [W-1:0] sh_q, sh_d;
  logic [W-1:0] up_q, up_d;

  always_comb begin
    sh_d = sh_q;
    if (shift_en) begin
      sh_d = {si, sh_q[W-1:1]};
    end
  end

  always_comb begin
    up_d = up_q;
    if (upd_en) begin
      up_d = sh_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
      up_q <= '0;
    end else begin
      sh_q <= sh_d;
      up_q <= up_d;
    end
  end

  assign so     = sh_q[0];
  assign active = up_q;

endmodule

// File: rtl/wir_die_node.sv
// Die-level register followed by splice-able core segments.
module wir_die_node #(
  parameter int DIE_W  = 5,
  parameter int CORES  = 2,
  parameter int CORE_W = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    shift_en,
  input  logic                    upd_en,
  input  logic                    si,
  output logic                    so,
  output logic                    spliced,
  output logic [DIE_W-1:0]        die_instr,
  output logic [CORES*CORE_W-1:0] core_instr
);
  import wir_chain_pkg::*;

  logic [CORES:0] link;
  logic           core_shift_en;
  logic           core_upd_en;

  wir_seg #(.W(DIE_W)) u_die_reg (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (shift_en),
    .upd_en   (upd_en),
    .si       (si),
    .so       (link[0]),
    .active   (die_instr)
  );

  // Splice decision taken from the active stage only.
  assign spliced       = splices(die_instr[TSEL_LSB +: TSEL_W]);
  assign core_shift_en = shift_en & spliced;
  assign core_upd_en   = upd_en & spliced;

  for (genvar c = 0; c < CORES; c++) begin : g_core
    wir_seg #(.W(CORE_W)) u_core_reg (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (core_shift_en),
      .upd_en   (core_upd_en),
      .si       (link[c]),
      .so       (link[c+1]),
      .active   (core_instr[c*CORE_W +: CORE_W])
    );
  end

  assign so = spliced ? link[CORES] : link[0];

endmodule

// File: rtl/wir_len_sum.sv
// Current serial path length from the per-die splice flags.
module wir_len_sum #(
  parameter int NUM_DIES = 3,
  parameter int DIE_W    = 5,
  parameter int SEG_W    = 6,
  parameter int LEN_W    = 5
) (
  input  logic [NUM_DIES-1:0] spliced,
  output logic [LEN_W-1:0]    len
);

  localparam int BASE = NUM_DIES * DIE_W;

  always_comb begin
    len = LEN_W'(BASE);
    for (int d = 0; d < NUM_DIES; d++) begin
      if (spliced[d]) begin
        len = len + LEN_W'(SEG_W);
      end
    end
  end

endmodule

// File: rtl/wir_hier_chain.sv
module wir_hier_chain #(
  parameter int NUM_DIES      = 3,
  parameter int DIE_W         = 5,
  parameter int CORES_PER_DIE = 2,
  parameter int CORE_W        = 3
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic                                    wsi,
  input  logic                                    sel_wir,
  input  logic                                    shift_wr,
  input  logic                                    update_wr,
  output logic                                    wso,
  output logic [NUM_DIES*DIE_W-1:0]               die_instr,
  output logic [NUM_DIES*CORES_PER_DIE*CORE_W-1:0] core_instr,
  output logic [$clog2(NUM_DIES*(DIE_W+CORES_PER_DIE*CORE_W)+1)-1:0] chain_len
);

  localparam int SEG_W   = CORES_PER_DIE * CORE_W;
  localparam int MAX_LEN = NUM_DIES * (DIE_W + SEG_W);
  localparam int LEN_W   = $clog2(MAX_LEN + 1);

  logic                shift_en;
  logic                upd_en;
  logic [NUM_DIES:0]   thread;
  logic [NUM_DIES-1:0] spliced;

  assign shift_en  = sel_wir & shift_wr;
  assign upd_en    = sel_wir & update_wr;
  assign thread[0] = wsi;

  for (genvar d = 0; d < NUM_DIES; d++) begin : g_die
    wir_die_node #(
      .DIE_W  (DIE_W),
      .CORES  (CORES_PER_DIE),
      .CORE_W (CORE_W)
    ) u_node (
      .clk        (clk),
      .rst_n      (rst_n),
      .shift_en   (shift_en),
      .upd_en     (upd_en),
      .si         (thread[d]),
      .so         (thread[d+1]),
      .spliced    (spliced[d]),
      .die_instr  (die_instr[d*DIE_W +: DIE_W]),
      .core_instr (core_instr[d*SEG_W +: SEG_W])
    );
  end

  assign wso = thread[NUM_DIES];

  wir_len_sum #(
    .NUM_DIES (NUM_DIES),
    .DIE_W    (DIE_W),
    .SEG_W    (SEG_W),
    .LEN_W    (LEN_W)
  ) u_len (
    .spliced (spliced),
    .len     (chain_len)
  );

endmodule

// File: rtl/wir_hier_chain_chk.sv
module wir_hier_chain_chk #(
  parameter int NUM_DIES      = 3,
  parameter int DIE_W         = 5,
  parameter int CORES_PER_DIE = 2,
  parameter int CORE_W        = 3
) (
  input logic                                    clk,
  input logic                                    rst_n,
  input logic                                    sel_wir,
  input logic                                    update_wr,
  input logic [NUM_DIES*DIE_W-1:0]               die_instr,
  input logic [NUM_DIES*CORES_PER_DIE*CORE_W-1:0] core_instr,
  input logic [$clog2(NUM_DIES*(DIE_W+CORES_PER_DIE*CORE_W)+1)-1:0] chain_len
);
  import wir_chain_pkg::*;

  localparam int SEG_W   = CORES_PER_DIE * CORE_W;
  localparam int MIN_LEN = NUM_DIES * DIE_W;
  localparam int MAX_LEN = NUM_DIES * (DIE_W + SEG_W);

  AST_RST_BYPASS: assert property (@(posedge clk)
    !rst_n |-> (die_instr == '0 && core_instr == '0 && chain_len == MIN_LEN)); // R1

  AST_HOLD_NO_UPD: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel_wir && update_wr) |=> ($stable(die_instr) && $stable(core_instr))); // R2

  AST_LEN_AT_UPD_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel_wir && update_wr) |=> $stable(chain_len)); // R8

  AST_NOSEL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_wir |=> ($stable(die_instr) && $stable(chain_len))); // R9

  AST_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (chain_len >= MIN_LEN && chain_len <= MAX_LEN)); // R5

  for (genvar d = 0; d < NUM_DIES; d++) begin : g_excl
    AST_CORE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      (die_instr[d*DIE_W+TSEL_LSB +: TSEL_W] != TSEL_INTEST)
      |=> $stable(core_instr[d*SEG_W +: SEG_W])); // R6
  end

endmodule

bind wir_hier_chain wir_hier_chain_chk #(
  .NUM_DIES      (NUM_DIES),
  .DIE_W         (DIE_W),
  .CORES_PER_DIE (CORES_PER_DIE),
  .CORE_W        (CORE_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sel_wir    (sel_wir),
  .update_wr  (update_wr),
  .die_instr  (die_instr),
  .core_instr (core_instr),
  .chain_len  (chain_len)
);

// File: tb/wir_hier_chain_test.sv
module wir_hier_chain_test;

  localparam int PERIOD = 10;
  localparam int ND  = 3;
  localparam int DW  = 5;
  localparam int CPD = 2;
  localparam int CW  = 3;
  localparam int MAXL = ND * (DW + CPD * CW);
  localparam int CB  = ND * DW;   // core fields start here in a vector

  logic clk;
  logic rst_n;
  logic wsi;
  logic sel_wir;
  logic shift_wr;
  logic update_wr;
  logic wso;
  logic [ND*DW-1:0]     die_instr;
  logic [ND*CPD*CW-1:0] core_instr;
  logic [4:0]           chain_len;

  int checks = 0;
  int errors = 0;

  logic [DW-1:0] exp_die  [ND];
  logic [CW-1:0] exp_core [ND*CPD];

  wir_hier_chain uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .wsi        (wsi),
    .sel_wir    (sel_wir),
    .shift_wr   (shift_wr),
    .update_wr  (update_wr),
    .wso        (wso),
    .die_instr  (die_instr),
    .core_instr (core_instr),
    .chain_len  (chain_len)
  );

  initial clk = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  // Vector layout: die d at [d*5 +: 5]; core slot k at [15+k*3 +: 3].
  function automatic logic [32:0] mk(input logic [4:0] a, b, c,
                                     input logic [2:0] k0, k1, k2, k3, k4, k5);
    return {k5, k4, k3, k2, k1, k0, c, b, a};
  endfunction

  localparam logic [32:0] VECS [4] = '{
    mk(5'b00010, 5'b01001, 5'b01100, 3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd6),
    mk(5'b11011, 5'b11010, 5'b00110, 3'd5, 3'd3, 3'd7, 3'd1, 3'd0, 3'd0),
    mk(5'b01001, 5'b00010, 5'b00010, 3'd2, 3'd6, 3'd4, 3'd1, 3'd7, 3'd7),
    mk(5'b00000, 5'b00000, 5'b00000, 3'd0, 3'd0, 3'd3, 3'd5, 3'd6, 3'd2)
  };

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic exp_spliced(input int d);
    return exp_die[d][2:1] == 2'b01;
  endfunction

  function automatic logic [4:0] exp_len();
    int n = ND * DW;
    for (int d = 0; d < ND; d++) if (exp_spliced(d)) n += CPD * CW;
    return 5'(n);
  endfunction

  function automatic logic [ND*DW-1:0] exp_die_vec();
    logic [ND*DW-1:0] v;
    for (int d = 0; d < ND; d++) v[d*DW +: DW] = exp_die[d];
    return v;
  endfunction

  function automatic logic [ND*CPD*CW-1:0] exp_core_vec();
    logic [ND*CPD*CW-1:0] v;
    for (int k = 0; k < ND*CPD; k++) v[k*CW +: CW] = exp_core[k];
    return v;
  endfunction

  task automatic model_reset();
    for (int d = 0; d < ND; d++) exp_die[d] = '0;
    for (int k = 0; k < ND*CPD; k++) exp_core[k] = '0;
  endtask

  task automatic shift_word(input logic [7:0] w, input int n, input logic [4:0] len0);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check("R8 len steady while shifting", 64'(chain_len), 64'(len0));
      sel_wir  = 1'b1;
      shift_wr = 1'b1;
      wsi      = w[i];
    end
  endtask

  // Sends a vector in R4/R7 order: furthest register first, each LSB first.
  task automatic shift_stream(input logic [32:0] v);
    logic [4:0] len0 = exp_len();
    for (int d = ND-1; d >= 0; d--) begin
      if (exp_spliced(d)) begin
        for (int c = CPD-1; c >= 0; c--)
          shift_word(8'(v[CB + (d*CPD+c)*CW +: CW]), CW, len0);
      end
      shift_word(8'(v[d*DW +: DW]), DW, len0);
    end
    @(negedge clk);
    shift_wr = 1'b0;
    wsi      = 1'b0;
    check("R2 old die instr held after shift", 64'(die_instr), 64'(exp_die_vec()));
    check("R2 old core instr held after shift", 64'(core_instr), 64'(exp_core_vec()));
    check("R8 len unchanged before update", 64'(chain_len), 64'(len0));
  endtask

  task automatic apply_update(input logic [32:0] v);
    sel_wir   = 1'b1;
    update_wr = 1'b1;
    @(negedge clk);
    update_wr = 1'b0;
    sel_wir   = 1'b0;
    for (int d = 0; d < ND; d++) begin
      if (exp_spliced(d))
        for (int c = 0; c < CPD; c++)
          exp_core[d*CPD+c] = v[CB + (d*CPD+c)*CW +: CW];
    end
    for (int d = 0; d < ND; d++) exp_die[d] = v[d*DW +: DW];
    check("R3 die instr after update", 64'(die_instr), 64'(exp_die_vec()));
    check("R7 core instr after update (R6 unspliced kept)", 64'(core_instr), 64'(exp_core_vec()));
    check("R5 chain_len after update", 64'(chain_len), 64'(exp_len()));
  endtask

  task automatic measure_delay(input int exp_l, input string req);
    int k;
    sel_wir  = 1'b1;
    shift_wr = 1'b1;
    wsi      = 1'b0;
    repeat (MAXL) @(negedge clk);
    wsi = 1'b1;
    @(negedge clk);
    wsi = 1'b0;
    k = 1;
    while (wso !== 1'b1 && k < 60) begin
      @(negedge clk);
      k++;
    end
    shift_wr = 1'b0;
    sel_wir  = 1'b0;
    check(req, 64'(k), 64'(exp_l));
  endtask

  initial begin
    #(PERIOD*200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; wsi = 1'b0; sel_wir = 1'b0; shift_wr = 1'b0; update_wr = 1'b0;
    model_reset();
    repeat (3) @(negedge clk);
    check("R1 reset die instr", 64'(die_instr), 64'd0);
    check("R1 reset core instr", 64'(core_instr), 64'd0);
    check("R1 reset chain_len", 64'(chain_len), 64'(ND*DW));
    rst_n = 1'b1;
    @(negedge clk);

    measure_delay(ND*DW, "R4 die-only serial delay");
    check("R2 instr unchanged by shifting", 64'(die_instr), 64'd0);

    for (int i = 0; i < 4; i++) begin
      shift_stream(VECS[i]);
      apply_update(VECS[i]);
    end

    // Expand die 0 only and measure the lengthened path (R7)
    shift_stream(mk(5'b00010, 5'b0, 5'b0, 3'd1, 3'd4, 3'd0, 3'd0, 3'd0, 3'd0));
    apply_update(mk(5'b00010, 5'b0, 5'b0, 3'd1, 3'd4, 3'd0, 3'd0, 3'd0, 3'd0));
    measure_delay(ND*DW + CPD*CW, "R7 spliced serial delay");

    // R9: update and shift with sel_wir low are ignored
    shift_stream(mk(5'b0, 5'b0, 5'b0, 3'd7, 3'd7, 3'd0, 3'd0, 3'd0, 3'd0));
    sel_wir   = 1'b0;
    update_wr = 1'b1;
    @(negedge clk);
    update_wr = 1'b0;
    check("R9 update ignored without select", 64'(die_instr), 64'(exp_die_vec()));
    shift_wr = 1'b1;
    wsi      = 1'b1;
    repeat (25) @(negedge clk);
    shift_wr = 1'b0;
    wsi      = 1'b0;
    apply_update(mk(5'b0, 5'b0, 5'b0, 3'd7, 3'd7, 3'd0, 3'd0, 3'd0, 3'd0));
    check("R9 shift ignored without select", 64'(die_instr), 64'd0);

    // R10: reset in the middle of a shift
    shift_stream(mk(5'b0, 5'b00010, 5'b0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0));
    apply_update(mk(5'b0, 5'b00010, 5'b0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0));
    sel_wir  = 1'b1;
    shift_wr = 1'b1;
    wsi      = 1'b1;
    repeat (4) @(negedge clk);
    #(PERIOD/4);
    rst_n = 1'b0;
    #1;
    model_reset();
    check("R10 async reset die instr", 64'(die_instr), 64'd0);
    check("R10 async reset core instr", 64'(core_instr), 64'd0);
    check("R10 async reset chain_len", 64'(chain_len), 64'(ND*DW));
    @(negedge clk);
    sel_wir  = 1'b0;
    shift_wr = 1'b0;
    wsi      = 1'b0;
    rst_n    = 1'b1;
    @(negedge clk);
    measure_delay(ND*DW, "R10 die-only delay after reset");

    summary();
    $finish;
  end

endmodule